// File: doc/BRIEF.md
# Ladder Bit-Instruction Scan Engine

This block executes a small stored relay-logic program built only from single-bit instructions. It repeats a three-phase scan for as long as its run enable is high: first the input terminals are frozen into an input image, then the stored instruction words are executed one per clock from the first to the last, and finally the output image is copied to the output terminals in one step. Contacts within a rung combine as a logical AND. Branch markers group alternative paths into a logical OR. Each rung ends in one coil instruction that writes a bit of the image.

A coil's result is written to the image at the clock edge right after it executes. A later rung in the same scan therefore reads the fresh value. The image holds three regions: input bits, output bits that reach the terminals, and internal flag bits that reach no terminal. Any bit may be read by any number of contacts. The program is written word by word through a load port while the engine is idle. The number of words to execute is given by a length input.

Top module: `ladder_scan_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_term` is all zeros and `scan_done` is low.
- R2: A word with opcode 0 (examine-closed) in bits [7:5] and a bit address in bits [4:0] passes the rung condition through only when the addressed image bit is 1.
- R3: Opcode 1 (examine-open) passes the rung condition through only when the addressed image bit is 0.
- R4: Contacts in series AND together. Opcode 2 opens a branch group, opcode 3 starts the next parallel leg from the condition seen at the group's opening, and opcode 4 closes the group with the OR of all its legs.
- R5: Opcode 5 (energize) writes the rung result into its addressed bit on every scan, whether that result is 1 or 0.
- R6: Opcode 6 (latch) sets its bit to 1 when the rung is true and leaves the bit unchanged otherwise.
- R7: Opcode 7 (unlatch) clears its bit to 0 when the rung is true and leaves the bit unchanged otherwise.
- R8: Input terminals are sampled once, at the start of each scan. Changes to `in_term` while the rungs run have no effect until the next scan.
- R9: A coil's write becomes visible to every later instruction of the same scan.
- R10: Image addresses 8 to 15 are output bits k = addr-8, copied to `out_term[k]` only after the last rung. The copy comes with a `scan_done` pulse one cycle wide, so back-to-back scans of L words repeat every L+2 cycles.
- R11: If `run` drops mid-scan, the scan still completes with its copy and its pulse. After that, `out_term` holds its value and no further pulses occur.
- R12: Image addresses 0 to 7 are input bits and 16 to 31 are internal flags. Flags can be written and read by the program but never show on `out_term`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Scans repeat while high |
| in_term | input | 8 | Input terminals |
| out_term | output | 8 | Output terminals, updated at the end of each scan |
| scan_done | output | 1 | One-cycle pulse when a scan's output copy happens |
| prog_we | input | 1 | Program word write strobe |
| prog_waddr | input | 5 | Program word index to write |
| prog_wdata | input | 8 | Program word: opcode [7:5], bit address [4:0] |
| prog_len | input | 6 | Number of program words executed per scan |

## Verification
The checks assume the program is well formed. Every branch group is closed before its rung's coil, and groups are never nested. They also assume that program words and `prog_len` change only while the engine is idle, and that `prog_len` never exceeds the program depth. The bench follows these rules: it loads each program only after `run` has been low long enough for the last scan to end, holds the length constant while scans run, and builds only flat branch groups. Input terminals, by contrast, are changed freely at any cycle, including in the middle of a scan, to exercise the snapshot rule.

// File: rtl/ladder_pkg.sv
package ladder_pkg;

    parameter int N_IN       = 8;
    parameter int N_OUT      = 8;
    parameter int N_FLAG     = 16;
    parameter int PROG_DEPTH = 32;

    localparam int N_BITS   = N_IN + N_OUT + N_FLAG;
    localparam int ADDR_W   = $clog2(N_BITS);
    localparam int OP_W     = 3;
    localparam int WORD_W   = OP_W + ADDR_W;
    localparam int PC_W     = $clog2(PROG_DEPTH);
    localparam int LEN_W    = PC_W + 1;
    localparam int OUT_BASE = N_IN;

    typedef enum logic [OP_W-1:0] {
        OP_CLOSED   = 3'd0,
        OP_OPEN     = 3'd1,
        OP_BR_OPEN  = 3'd2,
        OP_BR_NEXT  = 3'd3,
        OP_BR_CLOSE = 3'd4,
        OP_ENERGIZE = 3'd5,
        OP_LATCH    = 3'd6,
        OP_UNLATCH  = 3'd7
    } opcode_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SNAP = 2'd1,
        PH_EXEC = 2'd2,
        PH_COPY = 2'd3
    } phase_t;

    typedef struct packed {
        opcode_t             op;
        logic [ADDR_W-1:0]   addr;
    } instr_t;

    typedef struct packed {
        logic                en;
        logic [ADDR_W-1:0]   addr;
        logic                val;
    } wr_req_t;

    function automatic instr_t decode_word(input logic [WORD_W-1:0] w);
        instr_t r;
        r.op   = opcode_t'(w[WORD_W-1 -: OP_W]);
        r.addr = w[ADDR_W-1:0];
        return r;
    endfunction

    function automatic logic is_coil(input opcode_t op);
        return (op == OP_ENERGIZE) || (op == OP_LATCH) || (op == OP_UNLATCH);
    endfunction

endpackage

// File: rtl/ladder_prog_mem.sv
module ladder_prog_mem
    import ladder_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [PC_W-1:0]   waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PC_W-1:0]   raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] words [PROG_DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/ladder_bit_image.sv
module ladder_bit_image
    import ladder_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              snap_en,
    input  logic [N_IN-1:0]   in_term,
    input  wr_req_t           wr,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rdata,
    output logic [N_OUT-1:0]  out_img,
    output logic [N_BITS-1:0] image
);

    for (genvar i = 0; i < N_BITS; i++) begin : g_bit
        logic b_q;
        logic hit;
        assign hit = wr.en && (wr.addr == ADDR_W'(i));
        if (i < N_IN) begin : g_input
            always_ff @(posedge clk) begin
                if (rst) begin
                    b_q <= 1'b0;
                end else if (snap_en) begin
                    b_q <= in_term[i];
                end else if (hit) begin
                    b_q <= wr.val;
                end
            end
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (rst) begin
                    b_q <= 1'b0;
                end else if (hit) begin
                    b_q <= wr.val;
                end
            end
        end
        assign image[i] = b_q;
    end

    assign rdata   = image[raddr];
    assign out_img = image[OUT_BASE +: N_OUT];

endmodule

// File: rtl/ladder_rung_eval.sv
module ladder_rung_eval
    import ladder_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scan_start,
    input  logic    exec_en,
    input  instr_t  instr,
    input  logic    bit_val,
    output logic    rung_val,
    output wr_req_t wr
);

    logic acc_q, acc_d;
    logic base_q, base_d;
    logic orv_q, orv_d;
    logic contact;

    assign contact  = (instr.op == OP_OPEN) ? ~bit_val : bit_val;
    assign rung_val = acc_q;

    always_comb begin
        acc_d  = acc_q;
        base_d = base_q;
        orv_d  = orv_q;
        unique case (instr.op)
            OP_CLOSED, OP_OPEN: acc_d = acc_q & contact;
            OP_BR_OPEN: begin
                base_d = acc_q;
                orv_d  = 1'b0;
            end
            OP_BR_NEXT: begin
                orv_d = orv_q | acc_q;
                acc_d = base_q;
            end
            OP_BR_CLOSE: acc_d = orv_q | acc_q;
            default: acc_d = 1'b1;
        endcase
    end

    always_comb begin
        wr.addr = instr.addr;
        wr.en   = 1'b0;
        wr.val  = 1'b0;
        if (exec_en) begin
            unique case (instr.op)
                OP_ENERGIZE: begin
                    wr.en  = 1'b1;
                    wr.val = acc_q;
                end
                OP_LATCH: begin
                    wr.en  = acc_q;
                    wr.val = 1'b1;
                end
                OP_UNLATCH: begin
                    wr.en  = acc_q;
                    wr.val = 1'b0;
                end
                default: wr.en = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || scan_start) begin
            acc_q  <= 1'b1;
            base_q <= 1'b1;
            orv_q  <= 1'b0;
        end else if (exec_en) begin
            acc_q  <= acc_d;
            base_q <= base_d;
            orv_q  <= orv_d;
        end
    end

endmodule

// File: rtl/ladder_scan_engine.sv
module ladder_scan_engine
    import ladder_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [N_IN-1:0]   in_term,
    output logic [N_OUT-1:0]  out_term,
    output logic              scan_done,
    input  logic              prog_we,
    input  logic [PC_W-1:0]   prog_waddr,
    input  logic [WORD_W-1:0] prog_wdata,
    input  logic [LEN_W-1:0]  prog_len
);

    phase_t              phase_q;
    logic [PC_W-1:0]     pc_q;
    logic [WORD_W-1:0]   word;
    instr_t              instr;
    logic                bit_val;
    logic                rung_val;
    wr_req_t             wr_req;
    logic [N_OUT-1:0]    out_img;
    logic [N_BITS-1:0]   image;
    logic                exec_en;
    logic                snap_en;
    logic                last_word;

    assign exec_en   = (phase_q == PH_EXEC);
    assign snap_en   = (phase_q == PH_SNAP);
    assign instr     = decode_word(word);
    assign last_word = (({1'b0, pc_q} + LEN_W'(1)) == prog_len);

    ladder_prog_mem u_prog (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_waddr),
        .wdata (prog_wdata),
        .raddr (pc_q),
        .rdata (word)
    );

    ladder_bit_image u_img (
        .clk     (clk),
        .rst     (rst),
        .snap_en (snap_en),
        .in_term (in_term),
        .wr      (wr_req),
        .raddr   (instr.addr),
        .rdata   (bit_val),
        .out_img (out_img),
        .image   (image)
    );

    ladder_rung_eval u_eval (
        .clk        (clk),
        .rst        (rst),
        .scan_start (snap_en),
        .exec_en    (exec_en),
        .instr      (instr),
        .bit_val    (bit_val),
        .rung_val   (rung_val),
        .wr         (wr_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            pc_q      <= '0;
            out_term  <= '0;
            scan_done <= 1'b0;
        end else begin
            scan_done <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (run) begin
                        phase_q <= PH_SNAP;
                    end
                end
                PH_SNAP: begin
                    pc_q    <= '0;
                    phase_q <= (prog_len == '0) ? PH_COPY : PH_EXEC;
                end
                PH_EXEC: begin
                    pc_q <= pc_q + PC_W'(1);
                    if (last_word) begin
                        phase_q <= PH_COPY;
                    end
                end
                PH_COPY: begin
                    out_term  <= out_img;
                    scan_done <= 1'b1;
                    phase_q   <= run ? PH_SNAP : PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ladder_scan_chk.sv
module ladder_scan_chk
    import ladder_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [N_IN-1:0]   in_term,
    input logic [N_OUT-1:0]  out_term,
    input logic              scan_done,
    input phase_t            phase,
    input instr_t            instr,
    input wr_req_t           wr,
    input logic [N_BITS-1:0] image,
    input logic              rung_val
);

    AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SNAP) |=> (image[N_IN-1:0] == $past(in_term))); // R8

    AST_COIL_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> (image[$past(wr.addr)] == $past(wr.val))); // R9

    AST_ENERGIZE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && instr.op == OP_ENERGIZE)
        |=> (image[$past(instr.addr)] == $past(rung_val))); // R5

    AST_LATCH_SETS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && instr.op == OP_LATCH && rung_val)
        |=> image[$past(instr.addr)]); // R6

    AST_UNLATCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && instr.op == OP_UNLATCH && rung_val)
        |=> !image[$past(instr.addr)]); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> !scan_done); // R10

    AST_OUT_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_term) |-> scan_done); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |=> ($stable(out_term) && !scan_done)); // R11

endmodule

bind ladder_scan_engine ladder_scan_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_term   (in_term),
    .out_term  (out_term),
    .scan_done (scan_done),
    .phase     (phase_q),
    .instr     (instr),
    .wr        (wr_req),
    .image     (image),
    .rung_val  (rung_val)
);

// File: tb/ladder_scan_engine_tb.sv
module ladder_scan_engine_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic [7:0] in_term = '0;
    logic [7:0] out_term;
    logic       scan_done;
    logic       prog_we = 1'b0;
    logic [4:0] prog_waddr = '0;
    logic [7:0] prog_wdata = '0;
    logic [5:0] prog_len = '0;

    always #2.5 clk = ~clk;

    ladder_scan_engine u_dut (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .in_term    (in_term),
        .out_term   (out_term),
        .scan_done  (scan_done),
        .prog_we    (prog_we),
        .prog_waddr (prog_waddr),
        .prog_wdata (prog_wdata),
        .prog_len   (prog_len)
    );

    int n_chk  = 0;
    int n_fail = 0;
    string cur_req = "R1";

    // behavioural reference
    logic [7:0]  m_prog [32];
    logic [31:0] m_img;
    int          m_phase;
    int          m_left;
    logic [7:0]  exp_out;
    logic        exp_done;

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void exec_program(input int len);
        int acc = 1, base = 1, orv = 0;
        for (int k = 0; k < len; k++) begin
            int op = int'(m_prog[k][7:5]);
            int a  = int'(m_prog[k][4:0]);
            int b  = int'(m_img[a]);
            case (op)
                0: acc = acc & b;
                1: acc = acc & (b ^ 1);
                2: begin base = acc; orv = 0; end
                3: begin orv = orv | acc; acc = base; end
                4: acc = orv | acc;
                5: begin m_img[a] = acc[0]; acc = 1; end
                6: begin if (acc != 0) m_img[a] = 1'b1; acc = 1; end
                default: begin if (acc != 0) m_img[a] = 1'b0; acc = 1; end
            endcase
        end
    endfunction

    // model the next edge with the currently driven inputs, then compare
    task automatic step();
        if (prog_we) m_prog[prog_waddr] = prog_wdata;
        if (rst) begin
            m_phase = 0; m_img = '0; exp_out = '0; exp_done = 1'b0;
        end else begin
            exp_done = 1'b0;
            case (m_phase)
                0: if (run) m_phase = 1;
                1: begin
                    m_img[7:0] = in_term;
                    exec_program(int'(prog_len));
                    m_left  = int'(prog_len);
                    m_phase = (m_left == 0) ? 3 : 2;
                end
                2: begin
                    m_left--;
                    if (m_left == 0) m_phase = 3;
                end
                default: begin
                    exp_out  = m_img[15:8];
                    exp_done = 1'b1;
                    m_phase  = run ? 1 : 0;
                end
            endcase
        end
        @(negedge clk);
        check(out_term == exp_out, cur_req, out_term, exp_out);
        check(scan_done == exp_done, cur_req, {7'd0, scan_done}, {7'd0, exp_done});
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic load(input int idx, input int op, input int addr);
        prog_we    = 1'b1;
        prog_waddr = 5'(idx);
        prog_wdata = {3'(op), 5'(addr)};
        step();
        prog_we    = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R10: watchdog expired, actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int pulses;
        int gap;
        int t_last;
        @(negedge clk);
        cur_req = "R1";
        rst = 1'b1;
        cycles(3);
        rst = 1'b0;
        step();
        check(out_term == 8'h00, "R1", out_term, 8'h00);
        check(scan_done == 1'b0, "R1", {7'd0, scan_done}, 8'h00);

        // program A: seal-in start/stop, flag chain, examine-open
        cur_req = "R4";
        load(0, 2, 0);  load(1, 0, 0);  load(2, 3, 0);  load(3, 0, 8);
        load(4, 4, 0);  load(5, 1, 1);  load(6, 5, 8);
        load(7, 0, 2);  load(8, 5, 16); load(9, 0, 16); load(10, 5, 9);
        load(11, 1, 16); load(12, 5, 10);
        prog_len = 6'd13;

        cur_req = "R2";
        in_term = 8'b0000_0101;
        run = 1'b1;
        cycles(40);
        check(out_term == 8'h03, "R2", out_term, 8'h03);   // start + flag chain
        cur_req = "R4";
        in_term = 8'b0000_0100;
        cycles(40);
        check(out_term == 8'h03, "R4", out_term, 8'h03);   // seal branch holds
        cur_req = "R9";
        in_term = 8'b0000_0000;
        cycles(40);
        check(out_term == 8'h05, "R9", out_term, 8'h05);   // flag seen same scan
        check(out_term[1] == 1'b0, "R12", out_term, 8'h05);
        cur_req = "R3";
        in_term = 8'b0000_0010;
        cycles(40);
        check(out_term == 8'h04, "R3", out_term, 8'h04);   // stop opens contact
        cur_req = "R5";
        in_term = 8'b0000_0000;
        cycles(40);
        check(out_term == 8'h04, "R5", out_term, 8'h04);

        // R8: inputs toggling inside scans
        cur_req = "R8";
        for (int i = 0; i < 120; i++) begin
            in_term = 8'((i * 37 + 11) & 8'h07);
            step();
        end
        in_term = 8'b0000_0000;

        // R10: measure period between pulses
        cur_req = "R10";
        pulses = 0; t_last = -1; gap = 0;
        for (int i = 0; i < 60; i++) begin
            step();
            if (scan_done) begin
                if (t_last >= 0) gap = i - t_last;
                t_last = i;
            end
        end
        check(gap == 15, "R10", 8'(gap), 8'd15);

        // R11: drop run mid-scan
        cur_req = "R11";
        while (!scan_done) step();
        cycles(4);
        run = 1'b0;
        in_term = 8'b0000_0001;
        pulses = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (scan_done) pulses++;
        end
        check(pulses == 1, "R11", 8'(pulses), 8'd1);
        check(out_term == 8'h04, "R11", out_term, 8'h04);

        // program B: latch / unlatch on output bit 3 (addr 11)
        cur_req = "R6";
        load(0, 0, 0); load(1, 6, 11); load(2, 0, 1); load(3, 7, 11);
        prog_len = 6'd4;
        in_term = 8'b0000_0001;
        run = 1'b1;
        cycles(20);
        check(out_term[3] == 1'b1, "R6", out_term, 8'h08);
        in_term = 8'b0000_0000;
        cycles(20);
        check(out_term[3] == 1'b1, "R6", out_term, 8'h08);
        cur_req = "R7";
        in_term = 8'b0000_0010;
        cycles(20);
        check(out_term[3] == 1'b0, "R7", out_term, 8'h00);
        in_term = 8'b0000_0000;
        cycles(20);
        check(out_term[3] == 1'b0, "R7", out_term, 8'h00);
        run = 1'b0;
        cycles(10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule